// File: doc/BRIEF.md
# Vertical Blank Status Flag and Interrupt Request

This block holds the vertical-blank status bit of a video controller and produces the active-low non-maskable interrupt request for the CPU. A frame timer pulses one strobe on the pixel clock where vertical blank begins and another where it ends. The CPU side provides a one-cycle status-read strobe and the interrupt-enable control bit as last written. The block returns the flag value that the read sees, and drives the interrupt line low while the flag and the enable are both true.

The difficult part is the few pixel clocks around the set point. A read landing there may see the flag clear or set. A read one clock early cancels the flag for the whole frame. Reads and enable changes close to the set point can suppress the interrupt. All of these windows are exact to the clock. The interrupt line is a registered level, and the CPU is expected to act on its falling edge.

Top module: `vbl_nmi_unit`

## Requirements
- R1: After a synchronous reset the flag reads as 0 and `nmi_n_o` is 1.
- R2: A read in the cycle where `vbl_start_i` is high, or 1 or 2 cycles later, returns `rd_flag_o` = 1 when no earlier read blocked the set.
- R3: A read 1, 2, 3 or 4 cycles before the `vbl_start_i` cycle returns `rd_flag_o` = 0.
- R4: A status read clears the flag; a later read in the same blank returns 0.
- R5: A read exactly 1 cycle before the `vbl_start_i` cycle keeps the flag from being set for that frame, so a read 6 cycles after the start cycle returns 0. A read 2 or more cycles before does not block it.
- R6: With the enable held at 1 and no reads, `nmi_n_o` stays 1 in the cycle after the start cycle and goes to 0 two cycles after it.
- R7: A read 1 cycle before, in, or 1 cycle after the start cycle leaves `nmi_n_o` at 1 for the whole frame. A read 2 or more cycles before or after it still lets one falling edge of `nmi_n_o` occur.
- R8: If `nmi_en_i` first goes to 0 at 1 cycle before, in, or 1 cycle after the start cycle, no falling edge occurs. If it first goes to 0 at 2 or more cycles after the start cycle, one falling edge occurs.
- R9: If `nmi_en_i` rises while the flag is set, `nmi_n_o` is 0 in the next cycle.
- R10: Dropping and raising the enable again inside one blank gives a second falling edge of `nmi_n_o`.
- R11: A pulse on `vbl_end_i` clears the flag and returns `nmi_n_o` to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| vbl_start_i | input | 1 | One-cycle pulse at the start of vertical blank |
| vbl_end_i | input | 1 | One-cycle pulse at the end of vertical blank |
| stat_rd_i | input | 1 | One-cycle status-register read strobe |
| nmi_en_i | input | 1 | Interrupt enable control bit as written by the CPU |
| rd_flag_o | output | 1 | Flag value returned to a read in this cycle |
| nmi_n_o | output | 1 | Interrupt request, active low |

## Verification
The main patterns place a single status read at each offset from four cycles before the set point to three cycles after it. They also move the first low cycle of the enable from one cycle before the set point to three after. Each pattern records three things: the value the read saw, a later probe read, and the number of falling edges of the interrupt line. The offsets that sit on either side of each window boundary tell a one-clock-early or one-clock-late design apart from a correct one. Directed frames then check the exact cycle the interrupt line falls, raising the enable while the flag is already set, a second interrupt from toggling the enable, and the clear at the end strobe.

// File: rtl/vbl_pkg.sv
package vbl_pkg;

    // Reads this many cycles ahead of the set point block the flag.
    localparam int unsigned BLOCK_LEAD = 1;

    typedef struct packed {
        logic start;
        logic stop;
        logic rd;
    } vbl_evt_t;

    // Value a read returns: held flag, or the flag arriving in this cycle.
    function automatic logic read_view(input logic held, input logic arriving);
        return held | arriving;
    endfunction

endpackage

// File: rtl/vbl_flag_core.sv
module vbl_flag_core
    import vbl_pkg::*;
#(
    parameter int unsigned LEAD = BLOCK_LEAD
) (
    input  logic     clk,
    input  logic     rst,
    input  vbl_evt_t evt,
    output logic     flag_q,
    output logic     rd_val
);
    localparam int unsigned HW = (LEAD < 1) ? 1 : LEAD;

    logic [HW-1:0] rd_hist;
    logic          blocked;
    logic          set_now;
    logic          flag_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_hist <= '0;
        end else begin
            rd_hist[0] <= evt.rd;
            for (int i = 1; i < int'(HW); i++) begin
                rd_hist[i] <= rd_hist[i-1];
            end
        end
    end

    assign blocked = rd_hist[HW-1];
    assign set_now = evt.start & ~blocked;

    always_comb begin
        flag_d = flag_q;
        if (evt.rd || evt.stop) begin
            flag_d = 1'b0;
        end else if (set_now) begin
            flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign rd_val = read_view(flag_q, set_now);

    // R4
    rd_clears_chk: assert property (@(posedge clk) disable iff (rst)
        evt.rd |=> !flag_q);

    // R11
    end_clears_chk: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !flag_q);

    // R2
    set_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(evt.start));

    // R5
    early_block_chk: assert property (@(posedge clk) disable iff (rst)
        (blocked && evt.start) |=> !flag_q);

endmodule

// File: rtl/vbl_irq_gen.sv
module vbl_irq_gen (
    input  logic clk,
    input  logic rst,
    input  logic flag_q,
    input  logic rd,
    input  logic stop,
    input  logic enable,
    output logic nmi_n
);
    logic req_q;

    // The request trails the flag by one cycle so a read or an enable drop
    // in the first flagged cycle still cancels it.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else begin
            req_q <= flag_q & enable & ~rd & ~stop;
        end
    end

    assign nmi_n = ~req_q;

    // R6
    fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(nmi_n) |-> $past(flag_q && enable));

    // R8
    disable_release_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> nmi_n);

    // R7
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        rd |=> nmi_n);

    // R11
    end_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> nmi_n);

endmodule

// File: rtl/vbl_nmi_unit.sv
module vbl_nmi_unit
    import vbl_pkg::*;
#(
    parameter int unsigned LEAD = BLOCK_LEAD
) (
    input  logic clk,
    input  logic rst,
    input  logic vbl_start_i,
    input  logic vbl_end_i,
    input  logic stat_rd_i,
    input  logic nmi_en_i,
    output logic rd_flag_o,
    output logic nmi_n_o
);
    vbl_evt_t evt;
    logic     flag_q;

    assign evt = '{start: vbl_start_i, stop: vbl_end_i, rd: stat_rd_i};

    vbl_flag_core #(.LEAD(LEAD)) u_flag (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .flag_q (flag_q),
        .rd_val (rd_flag_o)
    );

    vbl_irq_gen u_irq (
        .clk    (clk),
        .rst    (rst),
        .flag_q (flag_q),
        .rd     (evt.rd),
        .stop   (evt.stop),
        .enable (nmi_en_i),
        .nmi_n  (nmi_n_o)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (nmi_n_o && !rd_flag_o) || rst);

endmodule

// File: tb/vbl_nmi_unit_bench.sv
`timescale 1ns/1ps
module vbl_nmi_unit_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vbl_start_i = 1'b0;
    logic vbl_end_i = 1'b0;
    logic stat_rd_i = 1'b0;
    logic nmi_en_i = 1'b1;
    logic rd_flag_o;
    logic nmi_n_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vbl_nmi_unit u_vbl_nmi_unit (
        .clk         (clk),
        .rst         (rst),
        .vbl_start_i (vbl_start_i),
        .vbl_end_i   (vbl_end_i),
        .stat_rd_i   (stat_rd_i),
        .nmi_en_i    (nmi_en_i),
        .rd_flag_o   (rd_flag_o),
        .nmi_n_o     (nmi_n_o)
    );

    localparam int NONE  = 99;
    localparam int PRE   = 10;
    localparam int PROBE = 6;
    localparam int ENDT  = 9;

    typedef struct packed {
        logic signed [7:0] rd_off;
        logic signed [7:0] en_off;
        logic              exp_rd;
        logic              exp_probe;
        logic [1:0]        exp_nmi;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'sd99, 8'sd99, 1'b0, 1'b1, 2'd1},
        '{-8'sd4, 8'sd99, 1'b0, 1'b1, 2'd1},
        '{-8'sd3, 8'sd99, 1'b0, 1'b1, 2'd1},
        '{-8'sd2, 8'sd99, 1'b0, 1'b1, 2'd1},
        '{-8'sd1, 8'sd99, 1'b0, 1'b0, 2'd0},
        '{8'sd0,  8'sd99, 1'b1, 1'b0, 2'd0},
        '{8'sd1,  8'sd99, 1'b1, 1'b0, 2'd0},
        '{8'sd2,  8'sd99, 1'b1, 1'b0, 2'd1},
        '{8'sd3,  8'sd99, 1'b1, 1'b0, 2'd1},
        '{8'sd99, -8'sd1, 1'b0, 1'b1, 2'd0},
        '{8'sd99, 8'sd0,  1'b0, 1'b1, 2'd0},
        '{8'sd99, 8'sd1,  1'b0, 1'b1, 2'd0},
        '{8'sd99, 8'sd2,  1'b0, 1'b1, 2'd1},
        '{8'sd99, 8'sd3,  1'b0, 1'b1, 2'd1}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    initial begin
        int rd_seen;
        int probe_seen;
        int falls;
        logic prev_n;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "nmi_n in reset", int'(nmi_n_o), 1);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check("R1", "flag after reset", int'(rd_flag_o), 0);
        check("R1", "nmi_n after reset", int'(nmi_n_o), 1);

        for (int k = 0; k < NV; k++) begin
            int ro;
            int eo;
            ro = int'(VECS[k].rd_off);
            eo = int'(VECS[k].en_off);
            rd_seen = 0;
            probe_seen = 0;
            falls = 0;
            prev_n = nmi_n_o;
            for (int c = 0; c < PRE + 14; c++) begin
                int t;
                t = c - PRE;
                @(negedge clk);
                if (prev_n && !nmi_n_o) falls++;
                prev_n = nmi_n_o;
                vbl_start_i = (t == 0);
                vbl_end_i   = (t == ENDT);
                stat_rd_i   = (t == ro) || (t == PROBE);
                nmi_en_i    = !(eo != NONE && t >= eo && t <= ENDT);
                #1;
                if (t == ro) rd_seen = int'(rd_flag_o);
                if (t == PROBE) probe_seen = int'(rd_flag_o);
            end
            if (ro != NONE) begin
                check(ro < 0 ? "R3" : "R2", $sformatf("row %0d read value", k),
                      rd_seen, int'(VECS[k].exp_rd));
            end
            check(ro == NONE ? "R2" : (ro < 0 ? "R5" : "R4"),
                  $sformatf("row %0d probe read", k),
                  probe_seen, int'(VECS[k].exp_probe));
            check(ro != NONE ? "R7" : (eo != NONE ? "R8" : "R6"),
                  $sformatf("row %0d nmi edges", k),
                  falls, int'(VECS[k].exp_nmi));
        end

        // Directed frame: exact fall cycle, late enable, toggle, end strobe.
        falls = 0;
        prev_n = nmi_n_o;
        for (int c = 0; c < PRE + 16; c++) begin
            int t;
            t = c - PRE;
            @(negedge clk);
            if (prev_n && !nmi_n_o) falls++;
            prev_n = nmi_n_o;
            vbl_start_i = (t == 0);
            vbl_end_i   = (t == 10);
            stat_rd_i   = (t == 12);
            nmi_en_i    = (t >= 4 && t <= 5) || (t >= 8) || (t < -2);
            #1;
            if (t == 1)  check("R6", "nmi_n one cycle after start, enable low", int'(nmi_n_o), 1);
            if (t == 4)  check("R9", "nmi_n in enable-rise cycle", int'(nmi_n_o), 1);
            if (t == 5)  check("R9", "nmi_n after enable rise", int'(nmi_n_o), 0);
            if (t == 7)  check("R10", "nmi_n after enable drop", int'(nmi_n_o), 1);
            if (t == 9)  check("R10", "nmi_n after second rise", int'(nmi_n_o), 0);
            if (t == 11) check("R11", "nmi_n after end strobe", int'(nmi_n_o), 1);
            if (t == 12) check("R11", "flag after end strobe", int'(rd_flag_o), 0);
        end
        check("R10", "falling edges in toggled blank", falls, 2);

        // Directed frame: fall cycle with enable held high.
        for (int c = 0; c < PRE + 12; c++) begin
            int t;
            t = c - PRE;
            @(negedge clk);
            vbl_start_i = (t == 0);
            vbl_end_i   = (t == 8);
            stat_rd_i   = 1'b0;
            nmi_en_i    = 1'b1;
            #1;
            if (t == 1) check("R6", "nmi_n one cycle after start", int'(nmi_n_o), 1);
            if (t == 2) check("R6", "nmi_n two cycles after start", int'(nmi_n_o), 0);
            if (t == 9) check("R11", "nmi_n after end", int'(nmi_n_o), 1);
        end

        done = 1'b1;
        summary();
    end

endmodule